// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block takes one memory request at a time, a read or a write aimed at a bank, a row and a column. It turns that request into the short series of DRAM commands the request needs, and drives them onto a single command/address bus that all banks share. For each bank it holds the number of the open row and a flag that says whether any row is open. From these it decides whether the request is a row hit, needs a closed bank opened first, or must close a different row before opening its own.

A controller hands the sequencer requests over a valid/ready port. The sequencer sends at most one command per cycle. Two programmable gaps set how close commands may follow each other: one from precharge to activate, one from activate to the column command. The request is finished in the cycle its column command goes out, and a completion pulse marks that cycle.

Four named states carry out the work. In **IDLE** the block is ready and classifies an incoming request. Its transitions are *accept-hit* to COL, *accept-closed* to ACT and *accept-conflict* to PRE. In **PRE** a precharge is issued, followed by *pre-issued* to ACT. In **ACT** the block waits for the precharge gap and then issues an activate, followed by *act-issued* to COL. In **COL** it waits for the activate gap and then issues the read or write, followed by *col-issued* back to IDLE.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset every bank counts as closed, `req_ready` is 1, and `cmd_valid` and `seq_done` are 0. The first request to any bank is therefore classed as closed-row.
- R2: A request to a bank with no open row produces an ACTIVATE (op code 2, carrying the request row) and then the column command (READ op 3 or WRITE op 4, carrying the column). Both commands carry class code 1.
- R3: A request whose row is already open in its bank produces only the column command, one cycle after acceptance, with class code 0.
- R4: A request to a bank that has another row open produces PRECHARGE (op 1), then ACTIVATE, then the column command. All three carry class code 2.
- R5: After a conflict the bank holds the new row. A further request to the new row is a hit, and a request to the old row is a conflict again.
- R6: Row state is kept separately per bank. Opening a row in one bank leaves the open row of every other bank unchanged.
- R7: The column command follows its ACTIVATE by exactly max(`act_gap`,1) cycles.
- R8: The ACTIVATE of a conflict follows its PRECHARGE by exactly max(`pre_gap`,1) cycles. The first command of any request comes one cycle after acceptance.
- R9: `req_ready` is low from acceptance until the column command has been issued. A request presented during that time is ignored and causes no command.
- R10: `seq_done` pulses only in the cycle of the column command, and `req_ready` is 1 again in the following cycle.
- R11: Every issued command carries the bank of its request on `cmd_bank` and the request class on `cmd_class` (0 hit, 1 closed, 2 conflict). When `cmd_valid` is 0, `cmd_op` is 0.
- R12: Successive requests to different columns of the same open row are all hits, whether they read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_gap | input | GAP_W | Minimum cycles from ACTIVATE to column command |
| pre_gap | input | GAP_W | Minimum cycles from PRECHARGE to ACTIVATE |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request accepted when both are high |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 3 | 0 none, 1 PRECHARGE, 2 ACTIVATE, 3 READ, 4 WRITE |
| cmd_bank | output | BANK_W | Bank addressed by the command |
| cmd_row | output | ROW_W | Row for ACTIVATE, else 0 |
| cmd_col | output | COL_W | Column for READ/WRITE, else 0 |
| cmd_class | output | 2 | Class of the request the command serves |
| seq_done | output | 1 | Pulse with the column command of a request |

## Verification
The column command with its completion pulse and the arrival of the next request can fall into the same cycle. The bench provokes this by holding `req_valid` high with a different bank through a whole conflict sequence, and dropping it only in the cycle where completion is seen. It then judges that every command on the bus belongs to the first request, that ready stays low through the column cycle, and that ready returns exactly one cycle later. The timing of each command is compared against the cycle counts given by both gaps, including gaps of zero and larger gaps.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PRE  = 3'd1,
        OP_ACT  = 3'd2,
        OP_RD   = 3'd3,
        OP_WR   = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_CLOSED   = 2'd1,
        CLS_CONFLICT = 2'd2
    } req_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL
    } seq_state_e;

endpackage

// File: rtl/dram_row_table.sv
module dram_row_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] q_bank,
    output logic              q_open,
    output logic [ROW_W-1:0]  q_row
);

    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_W-1:0]     row_vec [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_b;
        logic [ROW_W-1:0] row_b;
        logic             sel_b;

        assign sel_b = (upd_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_b <= 1'b0;
                row_b  <= '0;
            end else if (act_en && sel_b) begin
                open_b <= 1'b1;
                row_b  <= upd_row;
            end else if (pre_en && sel_b) begin
                open_b <= 1'b0;
            end
        end

        assign open_vec[b] = open_b;
        assign row_vec[b]  = row_b;
    end

    always_comb begin
        q_open = 1'b0;
        q_row  = '0;
        if (int'(q_bank) < NUM_BANKS) begin
            q_open = open_vec[q_bank];
            q_row  = row_vec[q_bank];
        end
    end

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !open_vec[upd_bank]); // R4
    AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> open_vec[upd_bank]); // R4

endmodule

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= gap;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q <= GAP_W'(1));

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int GAP_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  act_gap,
    input  logic [GAP_W-1:0]  pre_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [1:0]        cmd_class,
    output logic              seq_done
);

    seq_state_e        state_q, state_d;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    req_cls_e          cls_q, cls_d;

    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic              accept;
    logic              act_fire, pre_fire;
    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              gap_done;
    cmd_op_e           op_d;

    dram_row_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (act_fire),
        .pre_en   (pre_fire),
        .upd_bank (bank_q),
        .upd_row  (row_q),
        .q_bank   (req_bank),
        .q_open   (look_open),
        .q_row    (look_row)
    );

    dram_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .gap     (gap_val),
        .expired (gap_done)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        if (!look_open) begin
            cls_d = CLS_CLOSED;
        end else if (look_row == req_row) begin
            cls_d = CLS_HIT;
        end else begin
            cls_d = CLS_CONFLICT;
        end
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            cls_q   <= CLS_HIT;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q   <= req_write;
                bank_q <= req_bank;
                row_q  <= req_row;
                col_q  <= req_col;
                cls_q  <= cls_d;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        op_d     = OP_NONE;
        act_fire = 1'b0;
        pre_fire = 1'b0;
        gap_load = 1'b0;
        gap_val  = act_gap;
        seq_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cls_d)
                        CLS_HIT:      state_d = ST_COL;
                        CLS_CLOSED:   state_d = ST_ACT;
                        CLS_CONFLICT: state_d = ST_PRE;
                        default:      state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PRE: begin
                op_d     = OP_PRE;
                pre_fire = 1'b1;
                gap_load = 1'b1;
                gap_val  = pre_gap;
                state_d  = ST_ACT;
            end
            ST_ACT: begin
                if (gap_done) begin
                    op_d     = OP_ACT;
                    act_fire = 1'b1;
                    gap_load = 1'b1;
                    gap_val  = act_gap;
                    state_d  = ST_COL;
                end
            end
            ST_COL: begin
                if (gap_done) begin
                    op_d     = wr_q ? OP_WR : OP_RD;
                    seq_done = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign cmd_valid = (op_d != OP_NONE);
    assign cmd_op    = op_d;
    assign cmd_bank  = cmd_valid ? bank_q : '0;
    assign cmd_row   = (op_d == OP_ACT) ? row_q : '0;
    assign cmd_col   = (op_d == OP_RD || op_d == OP_WR) ? col_q : '0;
    assign cmd_class = cmd_valid ? cls_q : CLS_HIT;

    // spacing monitor for the gap assertions
    logic [GAP_W:0] since_q;
    cmd_op_e        last_op_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q   <= '0;
            last_op_q <= OP_NONE;
        end else if (cmd_valid) begin
            since_q   <= (GAP_W+1)'(1);
            last_op_q <= op_d;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_COL_AFTER_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op_d == OP_RD || op_d == OP_WR) && last_op_q == OP_ACT)
        |-> (since_q >= {1'b0, act_gap})); // R7
    AST_ACT_AFTER_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_d == OP_ACT && last_op_q == OP_PRE)
        |-> (since_q >= {1'b0, pre_gap})); // R8
    AST_DONE_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (cmd_op == OP_RD || cmd_op == OP_WR)); // R10
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> req_ready); // R10
    AST_HIT_NO_ROW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class == CLS_HIT) |-> (cmd_op == OP_RD || cmd_op == OP_WR)); // R3
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid); // R9

endmodule

// File: tb/dram_cmd_seq_tb.sv
module dram_cmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 8;
    localparam int BW    = $clog2(NB);
    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int GAP_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [GAP_W-1:0] act_gap = 4'd2;
    logic [GAP_W-1:0] pre_gap = 4'd3;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [BW-1:0]    req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             cmd_valid;
    logic [2:0]       cmd_op;
    logic [BW-1:0]    cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic [1:0]       cmd_class;
    logic             seq_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .GAP_W(GAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .act_gap(act_gap), .pre_gap(pre_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_class(cmd_class),
        .seq_done(seq_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gmax1(input int g);
        return (g < 1) ? 1 : g;
    endfunction

    // Issue one request and check every command, its cycle and the handshake.
    task automatic run_req(input bit wr, input int bank, input int row, input int col,
                           input int exp_cls, input bit poke, input string req);
        int ops[8]; int tms[8]; int bks[8]; int cls[8]; int rws[8]; int cols[8];
        int eops[3]; int etms[3]; int ne; int n; int done_k; bit busy_ok;
        int a; int p;
        a = gmax1(int'(act_gap));
        p = gmax1(int'(pre_gap));
        if (exp_cls == 0) begin
            ne = 1; eops[0] = wr ? 4 : 3; etms[0] = 1;
        end else if (exp_cls == 1) begin
            ne = 2; eops[0] = 2; etms[0] = 1; eops[1] = wr ? 4 : 3; etms[1] = 1 + a;
        end else begin
            ne = 3; eops[0] = 1; etms[0] = 1; eops[1] = 2; etms[1] = 1 + p;
            eops[2] = wr ? 4 : 3; etms[2] = 1 + p + a;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr;
        req_bank = BW'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
        n = 0; done_k = 0; busy_ok = 1'b1;
        for (int k = 1; k <= 60 && done_k == 0; k++) begin
            @(negedge clk);
            if (req_ready) busy_ok = 1'b0;
            if (cmd_valid && n < 8) begin
                ops[n] = int'(cmd_op); tms[n] = k; bks[n] = int'(cmd_bank);
                cls[n] = int'(cmd_class); rws[n] = int'(cmd_row); cols[n] = int'(cmd_col);
                n++;
            end
            if (!cmd_valid) chk(cmd_op == 3'd0, "R11", "idle op code", int'(cmd_op), 0);
            if (seq_done) begin
                done_k = k;
                chk(cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4), "R10",
                    "done without column command", int'(cmd_op), wr ? 4 : 3);
            end
            if (poke && !seq_done) begin
                req_valid = 1'b1; req_write = ~wr;
                req_bank = BW'((bank + 1) % NB); req_row = ROW_W'(row + 1);
                req_col = COL_W'(col + 1);
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(busy_ok, "R9", "ready low while busy", int'(busy_ok), 1);
        chk(n == ne, req, "command count", n, ne);
        for (int i = 0; i < ne && i < n; i++) begin
            chk(ops[i] == eops[i], req, "command op", ops[i], eops[i]);
            chk(tms[i] == etms[i], (exp_cls == 2 && i == 1) ? "R8" :
                ((i == ne - 1 && ne > 1) ? "R7" : req), "command cycle", tms[i], etms[i]);
            chk(bks[i] == bank, "R11", "command bank", bks[i], bank);
            chk(cls[i] == exp_cls, "R11", "command class", cls[i], exp_cls);
            if (ops[i] == 2) chk(rws[i] == row, "R2", "activate row", rws[i], row);
            if (ops[i] >= 3) chk(cols[i] == col, req, "column address", cols[i], col);
        end
        chk(done_k == etms[ne-1], "R10", "done cycle", done_k, etms[ne-1]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after done", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R9", "no command from ignored request", int'(cmd_valid), 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", int'(cmd_valid), 0);
        chk(seq_done == 1'b0, "R1", "reset done", int'(seq_done), 0);
        run_req(1'b0, 0, 5, 1, 1, 1'b0, "R1");
    endtask

    task automatic t_same_row();
        run_req(1'b0, 0, 5, 2, 0, 1'b0, "R3");
        run_req(1'b1, 0, 5, 3, 0, 1'b0, "R12");
        run_req(1'b0, 0, 5, 2, 0, 1'b0, "R12");
    endtask

    task automatic t_banks();
        run_req(1'b1, 1, 7, 9, 1, 1'b0, "R2");
        run_req(1'b0, 0, 5, 4, 0, 1'b0, "R6");
        run_req(1'b0, 1, 7, 0, 0, 1'b0, "R6");
    endtask

    task automatic t_conflict();
        run_req(1'b0, 0, 9, 1, 2, 1'b0, "R4");
        run_req(1'b1, 0, 9, 8, 0, 1'b0, "R5");
        run_req(1'b0, 0, 5, 1, 2, 1'b0, "R5");
    endtask

    task automatic t_gaps();
        act_gap = 4'd0; pre_gap = 4'd0;
        run_req(1'b1, 1, 8, 2, 2, 1'b0, "R8");
        act_gap = 4'd5; pre_gap = 4'd1;
        run_req(1'b0, 2, 1, 6, 1, 1'b0, "R7");
        act_gap = 4'd1; pre_gap = 4'd6;
        run_req(1'b0, 1, 3, 3, 2, 1'b0, "R8");
        act_gap = 4'd2; pre_gap = 4'd3;
    endtask

    task automatic t_busy_overlap();
        run_req(1'b1, 2, 4, 5, 2, 1'b1, "R9");
        run_req(1'b0, 3, 0, 0, 1, 1'b0, "R9");
        run_req(1'b0, NB - 1, 16383, 1023, 1, 1'b0, "R2");
        run_req(1'b1, NB - 1, 16383, 0, 0, 1'b0, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_same_row();
        t_banks();
        t_conflict();
        t_gaps();
        t_busy_overlap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule